// File: doc/BRIEF.md
# Short-Memory Fractional Differintegrator

This block applies a fractional-order derivative or integral to a stream of signed fixed-point samples. It keeps the last L input samples in a window and weights the window element `k` samples old with a binomial weight `b_k` of order `c`. It sums the rounded products and multiplies the sum by a gain equal to `T^-c`. The result is one output sample for each input sample. Weights with `c > 0` make the block a fractional differentiator. Weights with `c < 0` make it a fractional integrator. The block itself does not depend on the sign of `c`.

The weights live in an external memory that the block reads through a simple address/data port. The gain is a plain register input. The block accepts samples through a valid/ready input and returns results through a valid/ready output. An input sample is taken only on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the result has been handed over. A result is handed over on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result waits unchanged. A source that asserts `in_valid` while `in_ready` is low loses that sample, and the block records this in a sticky status pin.

Top module: `frac_diffint`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `overrun` is 0. Every window entry is zero, so the first result after reset depends only on the first sample.
- R2: All data is two's complement Q7.17 on 24 bits. This covers samples, weights, gain and result. Let `x[n-k]` be the sample accepted `k` samples before the newest one, for k = 0..L-1. Each product `b_k*x[n-k]` is rounded as `(p + 2^16) >>> 17`. The rounded products are summed, and the sum `s` is scaled as `(s*gain + 2^16) >>> 17`.
- R3: For each accepted sample, the block drives `coef_addr` with every value k = 0..L-1 and never with a value of L or above. It uses `coef_data` from the clock cycle after the one in which the address was driven, so the memory read latency is one cycle.
- R4: A sample affects exactly the L results that start with its own. From the (L+1)-th result on it has no effect.
- R5: `out_valid` rises on the (L+2)-th rising edge after the edge that accepts a sample. `in_ready` is low from the accepting edge until the output handshake edge.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change. `in_ready` returns to 1 only in the cycle after the output handshake.
- R7: If `in_valid` is 1 on an edge where `in_ready` is 0, the sample is discarded and never enters the window. `overrun` becomes 1 on that edge and stays 1 until reset. This also applies to the edge on which the output handshake completes.
- R8: A scaled result outside the 24-bit range is clamped to 8388607 or to -8388608.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 24 | Input sample, Q7.17 |
| coef_addr | output | AW | Weight index k |
| coef_data | input | 24 | Weight b_k, Q7.17, one cycle after address |
| gain | input | 24 | Output gain T^-c, Q7.17 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Sink takes the result |
| out_data | output | 24 | Result, Q7.17, saturated |
| overrun | output | 1 | Sticky flag: a sample was offered while not ready |

## Verification
The output handshake that completes a result and a new sample offered by a careless source can land on the same edge. The block does not return to ready until the cycle after the handshake, so that sample is an overrun. The bench provokes this case directly. It holds `out_ready` low with a result pending, then raises `out_ready` and `in_valid` together on one edge with a marker value on `in_data`. Two checks judge the outcome. The result must be popped intact, with `overrun` set afterwards. The next legitimate sample must produce a value that the reference window, which never contains the marker, predicts exactly.

// File: rtl/fdi_pkg.sv
package fdi_pkg;
  typedef enum logic [1:0] {
    FDI_IDLE  = 2'd0,
    FDI_MAC   = 2'd1,
    FDI_SCALE = 2'd2,
    FDI_OUT   = 2'd3
  } fdi_state_t;
endpackage

// File: rtl/fdi_window.sv
module fdi_window #(
  parameter int L  = 100,
  parameter int DW = 24,
  parameter int AW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic signed [DW-1:0] wr_data,
  input  logic                 rd_step,
  output logic signed [DW-1:0] rd_data
);
  logic signed [DW-1:0] mem [L];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  // Circular storage: a write lands on wp, rp restarts on the newest entry
  // and walks backwards in age order while the MAC consumes it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < L; i++) mem[i] <= '0;
      wp <= '0;
      rp <= '0;
    end else if (wr_en) begin
      mem[wp] <= wr_data;
      rp      <= wp;
      wp      <= (wp == AW'(L-1)) ? '0 : wp + 1'b1;
    end else if (rd_step) begin
      rp <= (rp == '0) ? AW'(L-1) : rp - 1'b1;
    end
  end

  assign rd_data = mem[rp];

  AST_WP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(wp) < L) && (int'(rp) < L)); // R4
endmodule

// File: rtl/fdi_ctrl.sv
module fdi_ctrl
  import fdi_pkg::*;
#(
  parameter int L  = 100,
  parameter int AW = 7,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          out_ready,
  output logic          in_ready,
  output logic          out_valid,
  output logic          overrun,
  output logic          accept,
  output logic          step,
  output logic          scale_en,
  output logic [AW-1:0] coef_addr
);
  fdi_state_t state;
  logic [CW-1:0] cnt;

  assign in_ready  = (state == FDI_IDLE);
  assign out_valid = (state == FDI_OUT);
  assign accept    = in_valid && in_ready;
  assign step      = (state == FDI_MAC) && (cnt < CW'(L));
  assign scale_en  = (state == FDI_SCALE);
  assign coef_addr = step ? cnt[AW-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= FDI_IDLE;
      cnt     <= '0;
      overrun <= 1'b0;
    end else begin
      if (in_valid && !in_ready) overrun <= 1'b1;
      unique case (state)
        FDI_IDLE:  if (accept) begin
                     state <= FDI_MAC;
                     cnt   <= '0;
                   end
        FDI_MAC:   if (cnt == CW'(L)) state <= FDI_SCALE;
                   else cnt <= cnt + 1'b1;
        FDI_SCALE: state <= FDI_OUT;
        FDI_OUT:   if (out_ready) state <= FDI_IDLE;
        default:   state <= FDI_IDLE;
      endcase
    end
  end

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(coef_addr) < L); // R3
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready); // R5
endmodule

// File: rtl/fdi_mac.sv
module fdi_mac #(
  parameter int DW    = 24,
  parameter int FW    = 17,
  parameter int ACC_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 step,
  input  logic signed [DW-1:0] smp,
  input  logic signed [DW-1:0] coef,
  input  logic signed [DW-1:0] gain,
  input  logic                 scale_en,
  output logic signed [DW-1:0] y
);
  localparam int PW = 2 * DW;
  localparam int SW = ACC_W + DW;
  localparam logic signed [PW-1:0] HALF_P = PW'(64'sd1 <<< (FW-1));
  localparam logic signed [SW-1:0] HALF_S = SW'(64'sd1 <<< (FW-1));
  localparam logic signed [SW-1:0] MAX_S  = SW'((64'sd1 <<< (DW-1)) - 1);
  localparam logic signed [SW-1:0] MIN_S  = -SW'(64'sd1 <<< (DW-1));

  logic signed [DW-1:0]    smp_q;
  logic                    pv;
  logic signed [ACC_W-1:0] acc;
  logic signed [PW-1:0]    prod;
  logic signed [ACC_W-1:0] prod_rnd;
  logic signed [SW-1:0]    sprod;
  logic signed [SW-1:0]    srnd;

  // Sample is registered alongside the one-cycle weight read so that both
  // operands of a product refer to the same index k.
  always_comb begin
    prod     = PW'(coef) * PW'(smp_q);
    prod_rnd = ACC_W'((prod + HALF_P) >>> FW);
    sprod    = SW'(acc) * SW'(gain);
    srnd     = (sprod + HALF_S) >>> FW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      pv    <= 1'b0;
      acc   <= '0;
      y     <= '0;
    end else begin
      pv <= step;
      if (step) smp_q <= smp;
      if (clr)     acc <= '0;
      else if (pv) acc <= acc + prod_rnd;
      if (scale_en) begin
        if (srnd > MAX_S)      y <= DW'(MAX_S);
        else if (srnd < MIN_S) y <= DW'(MIN_S);
        else                   y <= DW'(srnd);
      end
    end
  end

  AST_CLR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !pv); // R2
endmodule

// File: rtl/frac_diffint.sv
module frac_diffint #(
  parameter int L     = 100,
  parameter int DW    = 24,
  parameter int FW    = 17,
  parameter int GUARD = 8,
  localparam int AW    = (L > 1) ? $clog2(L) : 1,
  localparam int CW    = $clog2(L + 1),
  localparam int ACC_W = DW + GUARD
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic [AW-1:0]        coef_addr,
  input  logic signed [DW-1:0] coef_data,
  input  logic signed [DW-1:0] gain,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_data,
  output logic                 overrun
);
  logic accept;
  logic step;
  logic scale_en;
  logic signed [DW-1:0] win_rd;

  fdi_ctrl #(.L(L), .AW(AW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .overrun(overrun),
    .accept(accept), .step(step), .scale_en(scale_en), .coef_addr(coef_addr)
  );

  fdi_window #(.L(L), .DW(DW), .AW(AW)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(in_data),
    .rd_step(step), .rd_data(win_rd)
  );

  fdi_mac #(.DW(DW), .FW(FW), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .step(step), .smp(win_rd),
    .coef(coef_data), .gain(gain), .scale_en(scale_en), .y(out_data)
  );

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
  AST_NO_ACCEPT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> overrun); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R7
endmodule

// File: tb/sim_frac_diffint.sv
module sim_frac_diffint;
  localparam int L  = 12;
  localparam int DW = 24;
  localparam int AW = $clog2(L);
  localparam longint QONE = 131072;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic [AW-1:0] coef_addr;
  logic signed [DW-1:0] coef_data = '0;
  logic signed [DW-1:0] gain = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic signed [DW-1:0] out_data;
  logic overrun;

  always #2 clk = ~clk;

  frac_diffint #(.L(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_addr(coef_addr), .coef_data(coef_data),
    .gain(gain), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .overrun(overrun)
  );

  int coefm [L];
  int hist  [L];
  longint exp_q [$];
  string  tag_q [$];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit rdy_auto = 1'b1;
  bit stall = 1'b0;
  bit addr_bad = 1'b0;
  longint last_out = 0;

  // R3: weight memory with one cycle of read latency
  always @(posedge clk) begin
    coef_data <= DW'(coefm[coef_addr]);
    if (int'(coef_addr) >= L) addr_bad <= 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (rdy_auto) out_ready = stall ? (cyc % 3 == 0) : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every output handshake
  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected result", out_data, 0);
      else begin
        longint e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_out = out_data;
        chk(longint'(out_data) == e, t, out_data, e);
      end
    end
  end

  function automatic longint model();
    longint acc = 0;
    longint s;
    for (int k = 0; k < L; k++)
      acc += (longint'(coefm[k]) * longint'(hist[k]) + 65536) >>> 17;
    s = (acc * longint'(gain) + 65536) >>> 17;
    if (s > 8388607) s = 8388607;
    if (s < -8388608) s = -8388608;
    return s;
  endfunction

  task automatic push_model(input int x, input string t);
    for (int k = L - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    exp_q.push_back(model());
    tag_q.push_back(t);
  endtask

  task automatic send(input int x, input string t);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(x);
    push_model(x, t);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0 || !in_ready) @(negedge clk);
  endtask

  task automatic set_order(input real c);
    real b = 1.0;
    coefm[0] = int'(QONE);
    for (int j = 1; j < L; j++) begin
      b = b * (1.0 - (1.0 + c) / real'(j));
      coefm[j] = $rtoi(b * 131072.0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    longint held;
    for (int k = 0; k < L; k++) hist[k] = 0;
    set_order(0.5);
    gain = DW'(QONE);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);

    // R5 latency with an impulse; the result also shows the cleared window (R1)
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(QONE);
    push_model(int'(QONE), "R1 first result");
    @(negedge clk);
    in_valid = 1'b0;
    n = 1;
    while (!out_valid && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == L + 3, "R5 latency", n, L + 3);
    @(negedge clk);
    chk(in_ready == 1'b1, "R6 ready after handshake", in_ready, 1);

    // R4: impulse response over the window, then it must vanish
    for (int i = 1; i < L; i++) send(0, "R4 impulse tail");
    send(0, "R4 dropped sample");
    send(0, "R4 dropped sample");
    wait_idle();
    chk(last_out == 0, "R4 window end", last_out, 0);

    // R2 differentiator on a sampled sine, with back-pressure (R6)
    stall = 1'b1;
    for (int i = 0; i < 20; i++)
      send($rtoi(2.0 * $sin(0.7 * i) * 131072.0), "R2 differentiator");
    wait_idle();

    // R2 integrator on a square wave, new gain
    set_order(-0.6);
    gain = DW'(39322);
    for (int i = 0; i < 20; i++)
      send(((i / 4) % 2 == 0) ? 196608 : -196608, "R2 integrator");
    wait_idle();
    stall = 1'b0;

    // R8 saturation in both directions
    gain = DW'(40 * QONE);
    for (int i = 0; i < 4; i++) send(30 * int'(QONE), "R8 clamp high");
    wait_idle();
    chk(last_out == 8388607, "R8 positive limit", last_out, 8388607);
    for (int i = 0; i < L + 2; i++) send(-30 * int'(QONE), "R8 clamp low");
    wait_idle();
    chk(last_out == -8388608, "R8 negative limit", last_out, -8388608);
    chk(addr_bad == 1'b0, "R3 address range", addr_bad, 0);

    // R6 hold and R7 collision of a stray sample with the output handshake
    gain = DW'(QONE);
    @(negedge clk);
    rdy_auto = 1'b0;
    out_ready = 1'b0;
    send(int'(QONE) / 2, "R7 result before stray");
    while (!out_valid) @(negedge clk);
    held = out_data;
    repeat (3) @(negedge clk);
    chk(longint'(out_data) == held && out_valid, "R6 held result", out_data, held);
    chk(overrun == 1'b0, "R7 no overrun yet", overrun, 0);
    out_ready = 1'b1;
    in_valid  = 1'b1;
    in_data   = DW'(7 * QONE);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(overrun == 1'b1, "R7 overrun set", overrun, 1);
    rdy_auto = 1'b1;
    send(int'(QONE) / 4, "R7 stray sample excluded");
    // a stray sample during the MAC phase is also ignored
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DW'(-5 * QONE);
    @(negedge clk);
    in_valid = 1'b0;
    send(-int'(QONE), "R7 stray during compute excluded");
    wait_idle();
    chk(overrun == 1'b1, "R7 overrun sticky", overrun, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule